// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block caches recently used page translations in front of a page table walker. A lookup presents a full virtual address. The virtual page number chooses a set and supplies a tag. All ways of that set are compared in parallel, and in the same cycle the block returns a hit flag, the physical address and the three access-control bits of the matching entry. The page offset does not take part in the lookup. It passes straight into the low bits of the physical address.

When the walker finishes resolving a miss, it writes the result through the fill port, and later lookups of that page hit. A fill goes to a free way if the set has one. In a full set it evicts the way named by that set's round-robin pointer. A flush input drops every cached translation in one cycle. Each line holds exactly one translation: a valid bit, the tag, a physical page number, and the supervisor, read and write permission bits.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every lookup misses and every set's round-robin pointer names way 0.
- R2: With the default 12-bit offset and 2 index bits, the set index is address bits [13:12] (the low bits of the virtual page number) and the tag is bits [31:14].
- R3: A lookup hits in the same cycle, with no register on the path, when a valid way of the indexed set holds the same tag. The physical address is then {stored page number, address bits [11:0]}, and the offset bits pass through unchanged.
- R4: On a hit, lk_sup, lk_rd and lk_wr return the stored permission bits. On a miss, these three bits and the page-number part of lk_pa are all zero.
- R5: A fill is written at the clock edge that samples fill_en, and it is visible to lookups from the next cycle on.
- R6: If no valid way of the target set already holds the fill tag, the fill goes to the lowest-numbered invalid way. No valid entry is evicted while an invalid way remains, and the pointer does not move.
- R7: A fill into a set whose ways are all valid replaces the way named by that set's pointer. The pointer then advances by one, modulo the way count. Sets keep separate pointers.
- R8: A fill whose tag already sits in a valid way of its set overwrites that way and leaves the pointer where it is.
- R9: flush clears every valid bit in one cycle. A fill in the same cycle as a flush is discarded.
- R10: At most one way of a set matches a lookup tag at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 32 | Physical address: page number from the entry, offset from lk_va |
| lk_sup | output | 1 | Entry requires supervisor mode |
| lk_rd | output | 1 | Entry allows reads |
| lk_wr | output | 1 | Entry allows writes |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number of the entry being written |
| fill_ppn | input | 20 | Physical page number of the entry |
| fill_sup | input | 1 | Supervisor bit of the entry |
| fill_rd | input | 1 | Read bit of the entry |
| fill_wr | input | 1 | Write bit of the entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest condition to reach from the ports is round-robin replacement. It needs a set whose ways are all valid, and then repeated misses into that same set, with the pointer's history running through several wraps. A single flush wipes out that history. The stimulus first fills one set in order and forces two evictions and a same-tag refill. It then runs a long random phase that draws tags from a pool only twice as large as the way count, with flushes kept rare. Sets therefore fill up and evict often. A behavioural reference model that tracks every way and pointer is compared against the ports on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // access-control bits carried with every cached translation
  typedef struct packed {
    logic sup;
    logic rd;
    logic wr;
  } tlb_perm_t;

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] tags_i [WAYS],
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [WAY_W-1:0] rr_ptr_i,
  output logic [WAY_W-1:0] sel_way_o,
  output logic             replace_o
);

  logic             match_any;
  logic [WAY_W-1:0] match_idx;
  logic             inv_any;
  logic [WAY_W-1:0] inv_idx;

  // scan from the top so the lowest-numbered candidate wins
  always_comb begin
    match_any = 1'b0;
    match_idx = '0;
    inv_any   = 1'b0;
    inv_idx   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_i[w] && (tags_i[w] == fill_tag_i)) begin
        match_any = 1'b1;
        match_idx = WAY_W'(w);
      end
      if (!valid_i[w]) begin
        inv_any = 1'b1;
        inv_idx = WAY_W'(w);
      end
    end
  end

  always_comb begin
    replace_o = 1'b0;
    if (match_any) begin
      sel_way_o = match_idx;
    end else if (inv_any) begin
      sel_way_o = inv_idx;
    end else begin
      sel_way_o = rr_ptr_i;
      replace_o = 1'b1;
    end
  end

endmodule

// File: rtl/tlb_set_bank.sv
module tlb_set_bank
  import tlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int PPN_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             fill_en_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  tlb_perm_t        fill_perm_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output tlb_perm_t        hit_perm_o
);

  logic [WAYS-1:0]  valid_q, valid_d;
  logic [WAY_W-1:0] rr_q, rr_d;
  logic [TAG_W-1:0] tag_q  [WAYS];
  logic [PPN_W-1:0] ppn_q  [WAYS];
  tlb_perm_t        perm_q [WAYS];
  logic [WAYS-1:0]  way_we;
  logic [WAY_W-1:0] sel_way;
  logic             replace;
  logic [WAYS-1:0]  hit_vec;

  tlb_victim_sel #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) u_victim (
    .valid_i    (valid_q),
    .tags_i     (tag_q),
    .fill_tag_i (fill_tag_i),
    .rr_ptr_i   (rr_q),
    .sel_way_o  (sel_way),
    .replace_o  (replace)
  );

  // next state: flush wins over fill
  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    way_we  = '0;
    if (flush_i) begin
      valid_d = '0;
    end else if (fill_en_i) begin
      way_we[sel_way]  = 1'b1;
      valid_d[sel_way] = 1'b1;
      if (replace) begin
        rr_d = (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  // entry payload: no reset, written only under its enable
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (way_we[w]) begin
        tag_q[w]  <= fill_tag_i;
        ppn_q[w]  <= fill_ppn_i;
        perm_q[w] <= fill_perm_i;
      end
    end
    assign hit_vec[w] = valid_q[w] && (tag_q[w] == lk_tag_i);
  end

  // AND-OR select; all zero when nothing matches
  always_comb begin
    hit_ppn_o  = '0;
    hit_perm_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_ppn_o  = hit_ppn_o  | (ppn_q[w] & {PPN_W{hit_vec[w]}});
      hit_perm_o = hit_perm_o | (perm_q[w] & {3{hit_vec[w]}});
    end
  end

  assign hit_o = |hit_vec;

  // R10
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  // R5
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !flush_i) |=>
      (valid_q[$past(sel_way)] && (tag_q[$past(sel_way)] == $past(fill_tag_i))));

  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en_i && !flush_i && replace) |=> $stable(rr_q));

  // R7
  rr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !flush_i && replace) |=> (rr_q != $past(rr_q)));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int OFF_W    = 12,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  localparam int SETS  = 1 << SET_BITS,
  localparam int TAG_W = VPN_W - SET_BITS,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_sup,
  output logic             lk_rd,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_sup,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             flush
);

  logic                rst_n_s;
  logic [VPN_W-1:0]    lk_vpn;
  logic [SET_BITS-1:0] lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [SET_BITS-1:0] fill_idx;
  logic [TAG_W-1:0]    fill_tag;
  tlb_perm_t           fill_perm;
  logic [SETS-1:0]     set_hit;
  logic [PPN_W-1:0]    set_ppn  [SETS];
  tlb_perm_t           set_perm [SETS];
  tlb_perm_t           sel_perm;

  tlb_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  assign lk_vpn    = lk_va[VA_W-1:OFF_W];
  assign lk_idx    = lk_vpn[SET_BITS-1:0];
  assign lk_tag    = lk_vpn[VPN_W-1:SET_BITS];
  assign fill_idx  = fill_vpn[SET_BITS-1:0];
  assign fill_tag  = fill_vpn[VPN_W-1:SET_BITS];
  assign fill_perm = '{sup: fill_sup, rd: fill_rd, wr: fill_wr};

  for (genvar s = 0; s < SETS; s++) begin : g_set
    tlb_set_bank #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
    ) u_set (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .flush_i     (flush),
      .fill_en_i   (fill_en && (fill_idx == SET_BITS'(s))),
      .fill_tag_i  (fill_tag),
      .fill_ppn_i  (fill_ppn),
      .fill_perm_i (fill_perm),
      .lk_tag_i    (lk_tag),
      .hit_o       (set_hit[s]),
      .hit_ppn_o   (set_ppn[s]),
      .hit_perm_o  (set_perm[s])
    );
  end

  assign lk_hit   = set_hit[lk_idx];
  assign sel_perm = set_perm[lk_idx];
  assign lk_pa    = {set_ppn[lk_idx], lk_va[OFF_W-1:0]};
  assign lk_sup   = sel_perm.sup;
  assign lk_rd    = sel_perm.rd;
  assign lk_wr    = sel_perm.wr;

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_hit |-> ((lk_pa[PA_W-1:OFF_W] == '0) && !lk_sup && !lk_rd && !lk_wr));

  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> !lk_hit);

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_va;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        lk_sup, lk_rd, lk_wr;
  logic        fill_en;
  logic [19:0] fill_vpn;
  logic [19:0] fill_ppn;
  logic        fill_sup, fill_rd, fill_wr;
  logic        flush;

  int compared;
  int mismatched;
  bit done;

  // reference model: 4 sets x 4 ways
  int m_valid [4][4];
  int m_tag   [4][4];
  int m_ppn   [4][4];
  int m_perm  [4][4];
  int m_ptr   [4];

  tlb_xlate i_tlb_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_va    (lk_va),
    .lk_hit   (lk_hit),
    .lk_pa    (lk_pa),
    .lk_sup   (lk_sup),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .fill_sup (fill_sup),
    .fill_rd  (fill_rd),
    .fill_wr  (fill_wr),
    .flush    (flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic cmp(input string lbl, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", lbl, got, exp);
    end
  endtask

  task automatic model_check(input string lbl);
    int idx, tag, eh, epa, eperm;
    idx = int'(lk_va[13:12]);
    tag = int'(lk_va[31:14]);
    eh = 0; epa = int'(lk_va[11:0]); eperm = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_valid[idx][w] != 0 && m_tag[idx][w] == tag) begin
        eh = 1;
        epa = (m_ppn[idx][w] << 12) | int'(lk_va[11:0]);
        eperm = m_perm[idx][w];
      end
    end
    cmp({lbl, " R3 hit"}, int'(lk_hit), eh);
    cmp({lbl, " R3 pa"}, int'(lk_pa), epa);
    cmp({lbl, " R4 perm"}, int'({lk_sup, lk_rd, lk_wr}), eperm);
  endtask

  task automatic model_update(input bit fe, input int fv, input int fp,
                              input int fperm, input bit fl);
    int idx, tag, way;
    if (fl) begin
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) m_valid[s][w] = 0;
    end else if (fe) begin
      idx = fv & 3;
      tag = fv >> 2;
      way = -1;
      for (int w = 0; w < 4; w++)
        if (way < 0 && m_valid[idx][w] != 0 && m_tag[idx][w] == tag) way = w;
      for (int w = 0; w < 4; w++)
        if (way < 0 && m_valid[idx][w] == 0) way = w;
      if (way < 0) begin
        way = m_ptr[idx];
        m_ptr[idx] = (m_ptr[idx] + 1) % 4;
      end
      m_valid[idx][way] = 1;
      m_tag[idx][way]   = tag;
      m_ppn[idx][way]   = fp;
      m_perm[idx][way]  = fperm;
    end
  endtask

  // one clock: drive, check combinational result, then step model
  task automatic cyc(input string lbl, input logic [31:0] va, input bit fe,
                     input int fv, input int fp, input int fperm, input bit fl);
    @(negedge clk);
    lk_va    = va;
    fill_en  = fe;
    fill_vpn = fv[19:0];
    fill_ppn = fp[19:0];
    {fill_sup, fill_rd, fill_wr} = fperm[2:0];
    flush    = fl;
    #1;
    model_check(lbl);
    @(posedge clk);
    model_update(fe, fv, fp, fperm, fl);
  endtask

  function automatic logic [31:0] va_of(input int tag, input int idx, input int off);
    return {tag[17:0], idx[1:0], off[11:0]};
  endfunction

  function automatic int vpn_of(input int tag, input int idx);
    return (tag << 2) | idx;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    compared = 0; mismatched = 0; done = 0;
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_valid[s][w] = 0; m_tag[s][w] = 0; m_ppn[s][w] = 0; m_perm[s][w] = 0;
      end
    end
    rst_n = 1'b0;
    lk_va = '0; fill_en = 0; fill_vpn = '0; fill_ppn = '0;
    fill_sup = 0; fill_rd = 0; fill_wr = 0; flush = 0;
    repeat (4) cyc("R1 in reset", va_of(0, 0, 12'h123), 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R1 after reset", va_of(i, i, 12'h0f0), 0, 0, 0, 0, 0);

    // R6 / R5: fill set 1 in order, free ways first
    for (int t = 1; t <= 4; t++)
      cyc("R6 fill free way", va_of(t, 1, 0), 1, vpn_of(t, 1), 'h100 + t, t & 7, 0);
    for (int t = 1; t <= 4; t++)
      cyc("R5 hit after fill", va_of(t, 1, 12'habc), 0, 0, 0, 0, 0);
    // R2: same tag, other index must miss
    cyc("R2 other set", va_of(2, 2, 12'h001), 0, 0, 0, 0, 0);
    // R7: set full, evict way 0 then way 1
    cyc("R7 evict", va_of(5, 1, 0), 1, vpn_of(5, 1), 'h205, 3'b110, 0);
    cyc("R7 evicted tag", va_of(1, 1, 12'h777), 0, 0, 0, 0, 0);
    cyc("R7 evict next", va_of(5, 1, 12'h010), 1, vpn_of(6, 1), 'h206, 3'b011, 0);
    cyc("R7 second evicted", va_of(2, 1, 12'h010), 0, 0, 0, 0, 0);
    // R8: refill an existing tag
    cyc("R8 refill", va_of(3, 1, 0), 1, vpn_of(3, 1), 'hfff3, 3'b101, 0);
    cyc("R8 refilled", va_of(3, 1, 12'h555), 0, 0, 0, 0, 0);
    cyc("R7 pointer kept", va_of(0, 1, 0), 1, vpn_of(7, 1), 'h207, 3'b111, 0);
    for (int t = 3; t <= 7; t++) cyc("R7 set1 state", va_of(t, 1, t), 0, 0, 0, 0, 0);
    // R7 per-set pointer independence
    for (int t = 1; t <= 5; t++)
      cyc("R7 set3 fill", va_of(t, 3, 0), 1, vpn_of(t, 3), 'h300 + t, 3'b010, 0);
    for (int t = 1; t <= 5; t++) cyc("R7 set3 state", va_of(t, 3, 1), 0, 0, 0, 0, 0);
    // R9: flush beats simultaneous fill
    cyc("R9 flush+fill", va_of(4, 1, 0), 1, vpn_of(9, 0), 'h999, 3'b111, 1);
    cyc("R9 after flush", va_of(9, 0, 12'h042), 0, 0, 0, 0, 0);
    cyc("R9 after flush", va_of(4, 1, 12'h042), 0, 0, 0, 0, 0);

    // random phase: small tag pool keeps sets full (R7, R10)
    for (int n = 0; n < 4000; n++) begin
      int r, ft, fi, lt, li;
      bit fe, fl;
      r  = int'($urandom_range(0, 99));
      fe = (r < 35);
      fl = (r >= 98);
      ft = int'($urandom_range(0, 7));
      fi = int'($urandom_range(0, 3));
      lt = int'($urandom_range(0, 7));
      li = int'($urandom_range(0, 3));
      cyc("R10 random", va_of(lt, li, int'($urandom_range(0, 4095))), fe,
          vpn_of(ft, fi), int'($urandom_range(0, 1048575)), int'($urandom_range(0, 7)), fl);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule